// File: doc/BRIEF.md
# Multi-Master Bus Access and Arbitration Controller

This block is the bus-access front end of a two-wire serial master that shares open-drain clock and data lines with other masters. It never drives a line high: it only asserts a pull-low enable per line, and the line level it reads back is the wired-AND of every driver on the bus. Both lines pass through a two-flop synchronizer and a glitch filter. A tracker on the filtered levels marks the bus busy from any observed START until the matching STOP.

A request carries a 7-bit target address and a direction bit. The controller keeps a copy of the request and waits until the bus is free and both lines read high. It then issues a START and shifts out the address and the direction bit, most significant bit first. Each bit for which it releases the data line is compared with the sampled line while the clock is high. If the line is low, another master has won, so the block lets go of both lines in the next clock, pulses `lost`, and tries again from the bus-free wait. On the ninth clock it releases the data line and reads the target's acknowledge. It then finishes with a STOP.

Clock synchronization follows the wired-AND clock. The low half-period is timed by a divider. The high half-period counter starts only once the clock line is actually seen high, so a device holding the clock low stretches the period. Another master pulling the clock low early ends this block's high phase.

Top module: `i2c_mm_arbiter`

## Requirements
- R1: After reset both pull-low enables are 0, `grant`, `lost` and `ackValid` are 0, and `reqReady` is 1.
- R2: A START (data pulled low while the clock line is released and high) is issued only when the bus is not busy and both filtered lines are high. `grant` is high from the START to the end of the STOP.
- R3: The frame is the 7 address bits, most significant first, then the direction bit (1 = read). The data enable changes only while this block holds the clock low, and the data line is released for the ninth clock.
- R4: If the data line is released for a 1 bit but is sampled low while the clock is high, both enables are 0 in the next cycle and `lost` pulses for one cycle.
- R5: After a loss the block generates no STOP and stays off the bus while it is busy. It keeps the request and reissues the same frame once the bus is free.
- R6: The bus counts as busy from a filtered START until a filtered STOP. While busy, an accepted request does not drive either line.
- R7: The low half-period lasts HALF_CYC cycles. The high half-period is HALF_CYC cycles counted from when the clock line is first sampled high, so a clock held low by another device extends it.
- R8: At the end of the ninth clock `ackValid` pulses, with `ackOk`=1 if the data line was low (acknowledge) and 0 if it was high. A STOP follows and `grant` falls.
- R9: A line pulse shorter than FILT_LEN clock cycles is ignored by the loss detection and the bus tracker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Transfer request |
| reqReady | output | 1 | Request can be taken this cycle |
| reqAddr | input | ADDR_W | Target address |
| reqRead | input | 1 | Direction bit, 1 = read |
| grant | output | 1 | Block owns the bus (START through STOP) |
| lost | output | 1 | One-cycle pulse on lost arbitration |
| ackValid | output | 1 | One-cycle pulse when the acknowledge slot ends |
| ackOk | output | 1 | Target acknowledged, valid with ackValid |
| sclIn | input | 1 | Sampled clock line level |
| sdaIn | input | 1 | Sampled data line level |
| sclPullLow | output | 1 | Clock line pull-low enable |
| sdaPullLow | output | 1 | Data line pull-low enable |

## Verification
Address frames with mixed bits and both directions, acknowledged and not acknowledged, confirm the bit order, the direction bit and the way the acknowledge is read. An all-ones address with another driver pulling the data line low mid-frame separates a real loss from a single-cycle glitch on the same bit: the loss must drop the block off the bus and later reissue the frame, while the glitch must change nothing. A START made by another master before a request shows the busy hold-off. A clock held low during a release shows that the high phase is timed from the observed rising edge, not from the release.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_LOW, ST_HIGH, ST_STOP_LOW, ST_STOP_HIGH, ST_STOP_END
  } arbState_t;

  typedef struct packed {
    logic capture;  // take a new request into the hold register
    logic load;     // copy the held frame into the shifter
    logic shift;    // advance to the next frame bit
    logic cntClr;   // restart the half-period divider
  } dpCtl_t;
endpackage

// File: rtl/arb_line_filter.sv
module arb_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lineOut
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    syncQ;
  logic [CW-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= 2'b11;
      runCnt  <= '0;
      lineOut <= 1'b1;
    end else begin
      syncQ <= {syncQ[0], lineIn};
      if (syncQ[1] == lineOut) begin
        runCnt <= '0;
      end else if (runCnt == CW'(FILT_LEN - 1)) begin
        lineOut <= syncQ[1];
        runCnt  <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end

  // R9: the filtered level only moves to a value the synchronizer has been showing
  a_r9_filter_follows_sync: assert property (@(posedge clk) disable iff (!rstN)
    (lineOut != $past(lineOut)) |-> ($past(syncQ[1]) == lineOut));
endmodule

// File: rtl/arb_dp.sv
module arb_dp import arb_pkg::*; #(
  parameter int ADDR_W   = 7,
  parameter int HALF_CYC = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqRead,
  output logic              txBit,
  output logic              dataPhase,
  output logic              ackSlot,
  output logic              halfDone
);
  localparam int FRAME_W = ADDR_W + 1;
  localparam int BIT_CW  = $clog2(FRAME_W + 2);
  localparam int DIV_CW  = $clog2(HALF_CYC + 1);

  logic [FRAME_W-1:0] holdFrame;
  logic [FRAME_W-1:0] shiftQ;
  logic [BIT_CW-1:0]  bitCnt;
  logic [DIV_CW-1:0]  divCnt;

  assign txBit     = shiftQ[FRAME_W-1];
  assign dataPhase = bitCnt < BIT_CW'(FRAME_W);
  assign ackSlot   = bitCnt == BIT_CW'(FRAME_W);
  assign halfDone  = divCnt == DIV_CW'(HALF_CYC - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdFrame <= '0;
      shiftQ    <= '0;
      bitCnt    <= '0;
      divCnt    <= '0;
    end else begin
      if (ctl.capture) holdFrame <= {reqAddr, reqRead};
      if (ctl.load) begin
        shiftQ <= holdFrame;
        bitCnt <= '0;
      end else if (ctl.shift) begin
        shiftQ <= {shiftQ[FRAME_W-2:0], 1'b0};
        bitCnt <= bitCnt + 1'b1;
      end
      if (ctl.cntClr)     divCnt <= '0;
      else if (!halfDone) divCnt <= divCnt + 1'b1;
    end
  end

  // R3: never more than the frame bits plus the acknowledge slot
  a_r3_bit_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= BIT_CW'(FRAME_W));
  // R7: the divider saturates at the half-period
  a_r7_div_saturates: assert property (@(posedge clk) disable iff (!rstN)
    divCnt <= DIV_CW'(HALF_CYC - 1));
endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl import arb_pkg::*; (
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  output logic   reqReady,
  input  logic   sclF,
  input  logic   sdaF,
  input  logic   txBit,
  input  logic   dataPhase,
  input  logic   ackSlot,
  input  logic   halfDone,
  output dpCtl_t ctl,
  output logic   grant,
  output logic   lost,
  output logic   ackValid,
  output logic   ackOk,
  output logic   sclPull,
  output logic   sdaPull
);
  arbState_t state, stateNext;
  logic pending, pendingNext, busy, busyNext, sclPrev, sdaPrev;
  logic highSeen, highSeenNext, ackSample, ackSampleNext;
  logic sclPullNext, sdaPullNext, lostNext, ackValidNext;
  logic accept, busIdle, startSeen, stopSeen, arbLoss, endHigh;

  assign reqReady  = (state == ST_IDLE) && !pending;
  assign accept    = reqValid && reqReady;
  assign grant     = state != ST_IDLE;
  assign startSeen = sclPrev && sclF && sdaPrev && !sdaF;
  assign stopSeen  = sclPrev && sclF && !sdaPrev && sdaF;
  assign busIdle   = !busy && sclF && sdaF;
  assign arbLoss   = (state == ST_HIGH) && dataPhase && !sdaPull && sclF && !sdaF;
  assign endHigh   = (sclF && halfDone) || (!sclF && highSeen);
  assign busyNext  = startSeen ? 1'b1 : (stopSeen ? 1'b0 : busy);

  always_comb begin
    stateNext     = state;
    ctl           = '0;
    ctl.capture   = accept;
    sclPullNext   = sclPull;
    sdaPullNext   = sdaPull;
    lostNext      = 1'b0;
    ackValidNext  = 1'b0;
    highSeenNext  = highSeen;
    ackSampleNext = ackSample;
    pendingNext   = pending || accept;
    case (state)
      ST_IDLE: if (pending && busIdle) begin
        stateNext   = ST_START;
        sdaPullNext = 1'b1;
        ctl.cntClr  = 1'b1;
        ctl.load    = 1'b1;
      end
      ST_START: if (halfDone) begin
        stateNext   = ST_LOW;
        sclPullNext = 1'b1;
        ctl.cntClr  = 1'b1;
      end
      ST_LOW: begin
        sdaPullNext = ackSlot ? 1'b0 : !txBit;
        if (halfDone) begin
          stateNext    = ST_HIGH;
          sclPullNext  = 1'b0;
          ctl.cntClr   = 1'b1;
          highSeenNext = 1'b0;
        end
      end
      ST_HIGH: begin
        if (arbLoss) begin
          stateNext   = ST_IDLE;
          sclPullNext = 1'b0;
          sdaPullNext = 1'b0;
          lostNext    = 1'b1;
        end else begin
          if (sclF) begin
            highSeenNext = 1'b1;
            if (ackSlot) ackSampleNext = !sdaF;
          end else if (!highSeen) begin
            ctl.cntClr = 1'b1;
          end
          if (endHigh) begin
            sclPullNext = 1'b1;
            ctl.cntClr  = 1'b1;
            if (ackSlot) begin
              stateNext    = ST_STOP_LOW;
              ackValidNext = 1'b1;
            end else begin
              stateNext = ST_LOW;
              ctl.shift = 1'b1;
            end
          end
        end
      end
      ST_STOP_LOW: begin
        sdaPullNext = 1'b1;
        if (halfDone) begin
          stateNext   = ST_STOP_HIGH;
          sclPullNext = 1'b0;
          ctl.cntClr  = 1'b1;
        end
      end
      ST_STOP_HIGH: begin
        if (!sclF) begin
          ctl.cntClr = 1'b1;
        end else if (halfDone) begin
          stateNext   = ST_STOP_END;
          sdaPullNext = 1'b0;
          ctl.cntClr  = 1'b1;
        end
      end
      ST_STOP_END: if (halfDone) begin
        stateNext   = ST_IDLE;
        pendingNext = 1'b0;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      pending   <= 1'b0;
      busy      <= 1'b0;
      sclPrev   <= 1'b1;
      sdaPrev   <= 1'b1;
      highSeen  <= 1'b0;
      ackSample <= 1'b0;
      sclPull   <= 1'b0;
      sdaPull   <= 1'b0;
      lost      <= 1'b0;
      ackValid  <= 1'b0;
    end else begin
      state     <= stateNext;
      pending   <= pendingNext;
      busy      <= busyNext;
      sclPrev   <= sclF;
      sdaPrev   <= sdaF;
      highSeen  <= highSeenNext;
      ackSample <= ackSampleNext;
      sclPull   <= sclPullNext;
      sdaPull   <= sdaPullNext;
      lost      <= lostNext;
      ackValid  <= ackValidNext;
    end
  end

  assign ackOk = ackSample;

  // R2: ownership begins only from a cycle where both filtered lines were high and the bus free
  a_r2_start_on_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grant) |-> $past(sclF && sdaF && !busy));
  // R3: data enable held steady through the high phase
  a_r3_sda_steady_high: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HIGH && $past(state) == ST_HIGH) |-> $stable(sdaPull));
  // R4: a loss leaves both lines released
  a_r4_release_on_loss: assert property (@(posedge clk) disable iff (!rstN)
    lost |-> (!sdaPull && !sclPull && !grant));
  // R4: a loss follows a released bit read back low while the clock was high
  a_r4_loss_cause: assert property (@(posedge clk) disable iff (!rstN)
    lost |-> $past(sclF && !sdaF && !sdaPull));
  // R8: the acknowledge report comes while the block still owns the bus
  a_r8_ack_in_grant: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> (grant && sclPull));
  // R4: loss and acknowledge never coincide
  a_r4_single_outcome: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({lost, ackValid}));
endmodule

// File: rtl/i2c_mm_arbiter.sv
module i2c_mm_arbiter import arb_pkg::*; #(
  parameter int ADDR_W   = 7,
  parameter int HALF_CYC = 16,
  parameter int FILT_LEN = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqRead,
  output logic              grant,
  output logic              lost,
  output logic              ackValid,
  output logic              ackOk,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclPullLow,
  output logic              sdaPullLow
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] padIn, padFilt;
  dpCtl_t dpCtl;
  logic   txBit, dataPhase, ackSlot, halfDone;

  assign padIn = {sdaIn, sclIn};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    arb_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk     (clk),
      .rstN    (rstN),
      .lineIn  (padIn[g]),
      .lineOut (padFilt[g])
    );
  end

  arb_dp #(.ADDR_W(ADDR_W), .HALF_CYC(HALF_CYC)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (dpCtl),
    .reqAddr   (reqAddr),
    .reqRead   (reqRead),
    .txBit     (txBit),
    .dataPhase (dataPhase),
    .ackSlot   (ackSlot),
    .halfDone  (halfDone)
  );

  arb_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqReady  (reqReady),
    .sclF      (padFilt[0]),
    .sdaF      (padFilt[1]),
    .txBit     (txBit),
    .dataPhase (dataPhase),
    .ackSlot   (ackSlot),
    .halfDone  (halfDone),
    .ctl       (dpCtl),
    .grant     (grant),
    .lost      (lost),
    .ackValid  (ackValid),
    .ackOk     (ackOk),
    .sclPull   (sclPullLow),
    .sdaPull   (sdaPullLow)
  );
endmodule

// File: tb/tb_i2c_mm_arbiter.sv
module tb_i2c_mm_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 7;
  localparam int HALF_CYC   = 16;
  localparam int FILT_LEN   = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqRead = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic tbScl = 1'b0, tbSda = 1'b0, slaveAck = 1'b0, ackWanted = 1'b1;
  logic reqReady, grant, lost, ackValid, ackOk, sclPullLow, sdaPullLow;
  logic sclLine, sdaLine;

  int checks = 0, fails = 0, lostCnt = 0, stopCnt = 0;
  bit finished = 0;
  logic [7:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sclLine = !(sclPullLow || tbScl);
  assign sdaLine = !(sdaPullLow || tbSda || slaveAck);

  i2c_mm_arbiter #(.ADDR_W(ADDR_W), .HALF_CYC(HALF_CYC), .FILT_LEN(FILT_LEN)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqRead(reqRead), .grant(grant), .lost(lost),
    .ackValid(ackValid), .ackOk(ackOk), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclPullLow(sclPullLow), .sdaPullLow(sdaPullLow));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: decode frames on the shared lines and score them against the queue
  logic sclQ = 1'b1, sdaQ = 1'b1, active = 1'b0;
  logic [7:0] shreg = '0;
  int bitCnt = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (lost) lostCnt++;
      if (sclQ && sclLine && sdaQ && !sdaLine) begin
        active = 1'b1; bitCnt = 0;
      end else if (sclQ && sclLine && !sdaQ && sdaLine) begin
        active = 1'b0; bitCnt = 0; slaveAck = 1'b0; stopCnt++;
      end else if (active && !sclQ && sclLine && bitCnt < 8) begin
        shreg = {shreg[6:0], sdaLine};
        bitCnt++;
        if (bitCnt == 8) begin
          if (expQ.size() == 0) check(1'b0, "R3 unexpected frame", int'(shreg), 0);
          else begin
            logic [7:0] e;
            e = expQ.pop_front();
            check(shreg == e, "R3 frame bits", int'(shreg), int'(e));
          end
        end
      end else if (active && sclQ && !sclLine) begin
        if (bitCnt == 8) begin slaveAck = ackWanted; bitCnt = 9; end
        else if (bitCnt == 9) begin slaveAck = 1'b0; bitCnt = 10; end
      end
      sclQ = sclLine;
      sdaQ = sdaLine;
    end
  end

  // Driver: hand a request to the block and push the expected frame
  task automatic issue(input logic [ADDR_W-1:0] a, input logic rd);
    for (int n = 0; n < 3000 && !reqReady; n++) @(negedge clk);
    reqAddr = a; reqRead = rd; reqValid = 1'b1;
    expQ.push_back({a, rd});
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic waitGrant(output bit got);
    got = 0;
    for (int i = 0; i < 500; i++) begin
      if (grant) begin got = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic waitAck(output bit got, output bit okv);
    got = 0; okv = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (ackValid) begin got = 1; okv = ackOk; break; end
    end
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 500 && grant; i++) @(negedge clk);
    waitCycles(20);
  endtask

  task automatic waitSclRise(input int n);
    int cnt = 0;
    logic prev = sclLine;
    for (int i = 0; i < 4000 && cnt < n; i++) begin
      @(negedge clk);
      if (!prev && sclLine) cnt++;
      prev = sclLine;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    bit got, okv;
    int seen, hiLen, loLen, lost0;
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(5);
    // R1 reset state
    check(!sclPullLow && !sdaPullLow, "R1 enables released", int'({sclPullLow, sdaPullLow}), 0);
    check(!grant && !lost && !ackValid, "R1 outputs low", int'({grant, lost, ackValid}), 0);
    check(reqReady, "R1 ready", int'(reqReady), 1);

    // R3/R8: acknowledged write
    ackWanted = 1'b1;
    seen = stopCnt;
    issue(7'h5A, 1'b0);
    waitAck(got, okv);
    check(got, "R8 ack reported", int'(got), 1);
    check(okv, "R8 ackOk on acknowledge", int'(okv), 1);
    waitIdle();
    check(!grant, "R8 grant dropped", int'(grant), 0);
    check(stopCnt == seen + 1, "R8 stop on bus", stopCnt - seen, 1);

    // R3/R8: read with no acknowledge
    ackWanted = 1'b0;
    issue(7'h33, 1'b1);
    waitAck(got, okv);
    check(got && !okv, "R8 ackOk on no acknowledge", int'(okv), 0);
    waitIdle();

    // R6: bus taken by another master before the request
    ackWanted = 1'b1;
    tbSda = 1'b1; waitCycles(20);
    tbScl = 1'b1; waitCycles(20);
    issue(7'h4C, 1'b0);
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (grant || sclPullLow || sdaPullLow) seen++;
    end
    check(seen == 0, "R6 held off while busy", seen, 0);
    tbScl = 1'b0; waitCycles(20);
    tbSda = 1'b0;
    waitGrant(got);
    check(got, "R2 start after stop", int'(got), 1);
    check(sdaPullLow && !sclPullLow, "R2 start form", int'({sdaPullLow, sclPullLow}), 2);
    waitAck(got, okv);
    check(got && okv, "R6 deferred transfer acked", int'(okv), 1);
    waitIdle();

    // R4/R5: lost arbitration on a released bit
    lost0 = lostCnt;
    issue(7'h7F, 1'b0);
    waitGrant(got);
    waitSclRise(3);
    tbSda = 1'b1;
    got = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (lost) begin got = 1; break; end
    end
    check(got, "R4 lost pulse", int'(got), 1);
    check(!sclPullLow && !sdaPullLow, "R4 lines released", int'({sclPullLow, sdaPullLow}), 0);
    seen = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (grant || sclPullLow || sdaPullLow || lost) seen++;
    end
    check(seen == 0, "R5 off bus after loss", seen, 0);
    tbScl = 1'b1; waitCycles(20);
    tbScl = 1'b0; waitCycles(20);
    tbSda = 1'b0;
    waitAck(got, okv);
    check(got && okv, "R5 retried frame acked", int'(got), 1);
    check(lostCnt == lost0 + 1, "R4 single lost pulse", lostCnt - lost0, 1);
    waitIdle();

    // R9: one-cycle glitch on a released bit is ignored
    lost0 = lostCnt;
    issue(7'h7F, 1'b1);
    waitGrant(got);
    waitSclRise(5);
    waitCycles(2);
    #(CLK_PERIOD/4) tbSda = 1'b1;
    #(CLK_PERIOD/2) tbSda = 1'b0;
    waitAck(got, okv);
    check(got && okv, "R9 transfer completes", int'(got), 1);
    check(lostCnt == lost0, "R9 no loss on glitch", lostCnt - lost0, 0);
    waitIdle();

    // R7: clock held low by another device stretches the high phase
    issue(7'h21, 1'b0);
    waitGrant(got);
    waitSclRise(2);
    for (int i = 0; i < 200 && sclLine; i++) @(negedge clk);
    tbScl = 1'b1;
    waitCycles(100);
    tbScl = 1'b0;
    for (int i = 0; i < 20 && !sclLine; i++) @(negedge clk);
    hiLen = 0;
    while (sclLine && hiLen < 500) begin @(negedge clk); hiLen++; end
    check(hiLen >= HALF_CYC && hiLen <= HALF_CYC + 14, "R7 high after stretch", hiLen, HALF_CYC);
    loLen = 0;
    while (!sclLine && loLen < 500) begin @(negedge clk); loLen++; end
    check(loLen >= HALF_CYC && loLen <= HALF_CYC + 4, "R7 low half-period", loLen, HALF_CYC);
    waitAck(got, okv);
    check(got && okv, "R7 stretched transfer acked", int'(got), 1);
    waitIdle();

    check(expQ.size() == 0, "R3 all frames seen", expQ.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule